// File: doc/BRIEF.md
# Dual-Channel Bus Interconnect

This block joins eight bus initiators to nine targets over two channels that work at the same time. The first channel serves only target 0, which is usually a memory. The second channel is shared by targets 1 to 8, which are usually slow peripherals. Because the channels are separate, one initiator can use the memory while another initiator talks to a peripheral.

Each channel has its own round-robin arbiter. The arbiter chooses one of the initiators that want that channel and passes only that initiator's request forward. It keeps the grant for as long as the winner holds its cycle line high. In the second channel, the arbiter drives an intermediate bus. A demultiplexer then decodes the top address nibble and routes that bus to one of targets 1 to 8. If no target matches the address, the demultiplexer itself answers with a one-cycle error.

Each channel returns all-zero response signals to every initiator it has not granted. This means each initiator's response can be formed as the bitwise OR of the two channel returns. Both the address and the response paths are combinational.

Top module: `dual_chan_xbar`

## Requirements
- R1: An address whose top nibble is 0 goes to target 0. While channel A is free, target 0's cycle, strobe, write-enable, byte-select, address and write data equal the requester's in the same cycle. Target 0's acknowledge and read data return to that initiator in the same cycle.
- R2: An address whose top nibble is k, for k from 1 to 8, goes to target k. The read data that target k returns reaches the requesting initiator unchanged.
- R3: While one initiator uses target 0, another initiator can use a target from 1 to 8 in the same cycle. Both complete.
- R4: At most one of targets 1 to 8 sees cycle asserted at any time. A second initiator that wants channel B while it is busy causes no target cycle.
- R5: When a channel is released, the grant goes to the first requester found by searching upward, with wrap-around, from the index after the previous owner. After reset, initiator 0 has first priority.
- R6: A granted initiator keeps its channel for as long as its cycle line stays high. This holds even if an initiator with higher round-robin priority starts requesting.
- R7: An address whose top nibble is 9 to 15 asserts no target cycle. The requester gets error high in the cycle after its request, for exactly one cycle, with read data zero and no acknowledge.
- R8: An initiator that is not granted sees acknowledge, error and read data all zero. An initiator's acknowledge or error is high only while its cycle line is high.
- R9: During reset, all target cycle lines and all initiator acknowledge and error lines are low.
- R10: A waiting initiator gets no acknowledge until it is granted. Every request completes exactly once, in grant order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_cyc | input | NI | Cycle line per initiator |
| init_stb | input | NI | Strobe per initiator |
| init_we | input | NI | Write enable per initiator |
| init_sel | input | NI x SW | Byte selects per initiator |
| init_adr | input | NI x AW | Address per initiator |
| init_wdat | input | NI x DW | Write data per initiator |
| init_rdat | output | NI x DW | Merged read data per initiator |
| init_ack | output | NI | Merged acknowledge per initiator |
| init_err | output | NI | Merged error per initiator |
| tgt_cyc | output | NB+1 | Cycle line per target (index 0 is target 0) |
| tgt_stb | output | NB+1 | Strobe per target |
| tgt_we | output | NB+1 | Write enable per target |
| tgt_sel | output | (NB+1) x SW | Byte selects per target |
| tgt_adr | output | (NB+1) x AW | Address per target |
| tgt_wdat | output | (NB+1) x DW | Write data per target |
| tgt_rdat | input | (NB+1) x DW | Read data from each target |
| tgt_ack | input | NB+1 | Acknowledge from each target |
| tgt_err | input | NB+1 | Error from each target |

## Verification
Requests, target strobes and acknowledges all pass through the same cycle, because arbitration and decode are combinational. The only registers are the arbiter owner state and the decode-miss error. The bench therefore drives inputs just after a rising edge and checks target-side signals and acknowledges at the following falling edge. It expects a decode-miss error one falling edge later and expects that error to be gone on the edge after that. A scoreboard queue holds the responses in the grant order that the bench predicts from the round-robin rule. The bench pushes them in that order so that a monitor can pop and compare each acknowledge or error as it appears.

// File: rtl/dci_pkg.sv
package dci_pkg;
  // width of the address field used for region decode
  localparam int unsigned RGN_W = 4;

  // slot within channel B for a region value, -1 when unmapped
  function automatic int b_slot(input logic [7:0] rgn, input int base, input int nb);
    int s;
    s = int'(rgn) - base;
    return (s >= 0 && s < nb) ? s : -1;
  endfunction

  // expected read data of the bench-visible target model is not here: the
  // package only holds decode arithmetic shared by the RTL
endpackage

// File: rtl/dci_rr_arb.sv
module dci_rr_arb #(
  parameter int unsigned N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 gnt_vld
);
  localparam int unsigned IW = $clog2(N);

  logic          busy_q;
  logic [IW-1:0] own_q;
  logic          hold_w;
  logic [IW:0]   pick_w;

  // search upward from last+1 with wrap; nearest requester wins
  function automatic logic [IW:0] rr_pick(input logic [N-1:0] r, input logic [IW-1:0] last);
    logic [IW:0] res;
    int unsigned c;
    res = '0;
    for (int k = N; k >= 1; k--) begin
      c = (int'(last) + k) % N;
      if (r[c]) res = {1'b1, IW'(c)};
    end
    return res;
  endfunction

  assign hold_w = busy_q && req[own_q];
  assign pick_w = rr_pick(req, own_q);

  always_comb begin
    if (hold_w) begin
      gnt_vld = 1'b1;
      gnt_idx = own_q;
    end else begin
      gnt_vld = pick_w[IW];
      gnt_idx = pick_w[IW-1:0];
    end
  end

  assign gnt = gnt_vld ? (N'(1) << gnt_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      own_q  <= IW'(N - 1);
    end else begin
      busy_q <= gnt_vld;
      if (gnt_vld) own_q <= gnt_idx;
    end
  end

  assert_gnt_to_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> req[gnt_idx]);

  assert_grant_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |=> (!req[$past(gnt_idx)] || gnt_idx == $past(gnt_idx)));
endmodule

// File: rtl/dci_chan_merge.sv
module dci_chan_merge #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic [N-1:0]         stb,
  input  logic [N-1:0]         we,
  input  logic [N-1:0][SW-1:0] sel,
  input  logic [N-1:0][AW-1:0] adr,
  input  logic [N-1:0][DW-1:0] wdat,
  output logic                 ch_cyc,
  output logic                 ch_stb,
  output logic                 ch_we,
  output logic [SW-1:0]        ch_sel,
  output logic [AW-1:0]        ch_adr,
  output logic [DW-1:0]        ch_wdat,
  input  logic                 ch_ack,
  input  logic                 ch_err,
  input  logic [DW-1:0]        ch_rdat,
  output logic [N-1:0]         rsp_ack,
  output logic [N-1:0]         rsp_err,
  output logic [N-1:0][DW-1:0] rsp_rdat
);
  localparam int unsigned IW = $clog2(N);

  logic [N-1:0]  gnt;
  logic [IW-1:0] gnt_idx;
  logic          gnt_vld;

  dci_rr_arb #(.N(N)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .gnt_vld (gnt_vld)
  );

  assign ch_cyc  = gnt_vld;
  assign ch_stb  = gnt_vld && stb[gnt_idx];
  assign ch_we   = gnt_vld && we[gnt_idx];
  assign ch_sel  = gnt_vld ? sel[gnt_idx]  : '0;
  assign ch_adr  = gnt_vld ? adr[gnt_idx]  : '0;
  assign ch_wdat = gnt_vld ? wdat[gnt_idx] : '0;

  // responses reach only the granted initiator; all others see zero
  for (genvar i = 0; i < N; i++) begin : g_rsp
    assign rsp_ack[i]  = gnt[i] && ch_ack;
    assign rsp_err[i]  = gnt[i] && ch_err;
    assign rsp_rdat[i] = gnt[i] ? ch_rdat : '0;
  end
endmodule

// File: rtl/dci_chan_split.sv
module dci_chan_split #(
  parameter int unsigned NB     = 8,
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned SW     = 4,
  parameter int          B_BASE = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ch_cyc,
  input  logic                  ch_stb,
  input  logic                  ch_we,
  input  logic [SW-1:0]         ch_sel,
  input  logic [AW-1:0]         ch_adr,
  input  logic [DW-1:0]         ch_wdat,
  output logic                  ch_ack,
  output logic                  ch_err,
  output logic [DW-1:0]         ch_rdat,
  output logic [NB-1:0]         t_cyc,
  output logic [NB-1:0]         t_stb,
  output logic [NB-1:0]         t_we,
  output logic [NB-1:0][SW-1:0] t_sel,
  output logic [NB-1:0][AW-1:0] t_adr,
  output logic [NB-1:0][DW-1:0] t_wdat,
  input  logic [NB-1:0][DW-1:0] t_rdat,
  input  logic [NB-1:0]         t_ack,
  input  logic [NB-1:0]         t_err
);
  import dci_pkg::*;

  logic [RGN_W-1:0] rgn;
  int               slot;
  logic [NB-1:0]    hit;
  logic             miss_w;
  logic             miss_err_q;

  assign rgn    = ch_adr[AW-1 -: RGN_W];
  assign slot   = b_slot(8'(rgn), B_BASE, NB);
  assign miss_w = ch_cyc && ch_stb && (slot < 0);

  for (genvar t = 0; t < NB; t++) begin : g_tgt
    assign hit[t]    = (slot == t);
    assign t_cyc[t]  = ch_cyc && hit[t];
    assign t_stb[t]  = ch_stb && hit[t];
    assign t_we[t]   = ch_we;
    assign t_sel[t]  = ch_sel;
    assign t_adr[t]  = ch_adr;
    assign t_wdat[t] = ch_wdat;
  end

  always_comb begin
    ch_rdat = '0;
    for (int t = 0; t < NB; t++) begin
      if (hit[t]) ch_rdat = ch_rdat | t_rdat[t];
    end
  end

  assign ch_ack = |(t_ack & hit);
  assign ch_err = (|(t_err & hit)) || miss_err_q;

  // decode miss: answer with an error one cycle later, for one cycle
  always_ff @(posedge clk) begin
    if (!rst_n) miss_err_q <= 1'b0;
    else        miss_err_q <= miss_w && !miss_err_q;
  end

  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(t_cyc));

  assert_miss_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_w |-> (t_cyc == '0));

  assert_miss_err_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_w && !miss_err_q) |=> ch_err);

  assert_miss_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_err_q |=> !miss_err_q);
endmodule

// File: rtl/dual_chan_xbar.sv
module dual_chan_xbar #(
  parameter int unsigned NI     = 8,
  parameter int unsigned NB     = 8,
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned SW     = 4,
  parameter logic [3:0]  T0_RGN = 4'h0,
  parameter int          B_BASE = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NI-1:0]          init_cyc,
  input  logic [NI-1:0]          init_stb,
  input  logic [NI-1:0]          init_we,
  input  logic [NI-1:0][SW-1:0]  init_sel,
  input  logic [NI-1:0][AW-1:0]  init_adr,
  input  logic [NI-1:0][DW-1:0]  init_wdat,
  output logic [NI-1:0][DW-1:0]  init_rdat,
  output logic [NI-1:0]          init_ack,
  output logic [NI-1:0]          init_err,
  output logic [NB:0]            tgt_cyc,
  output logic [NB:0]            tgt_stb,
  output logic [NB:0]            tgt_we,
  output logic [NB:0][SW-1:0]    tgt_sel,
  output logic [NB:0][AW-1:0]    tgt_adr,
  output logic [NB:0][DW-1:0]    tgt_wdat,
  input  logic [NB:0][DW-1:0]    tgt_rdat,
  input  logic [NB:0]            tgt_ack,
  input  logic [NB:0]            tgt_err
);
  import dci_pkg::*;

  logic [NI-1:0] req_a, req_b;

  // channel A returns
  logic [NI-1:0]         a_ack, a_err;
  logic [NI-1:0][DW-1:0] a_rdat;
  // channel B intermediate bus and returns
  logic                  z_cyc, z_stb, z_we, z_ack, z_err;
  logic [SW-1:0]         z_sel;
  logic [AW-1:0]         z_adr;
  logic [DW-1:0]         z_wdat, z_rdat;
  logic [NI-1:0]         b_ack, b_err;
  logic [NI-1:0][DW-1:0] b_rdat;

  for (genvar i = 0; i < NI; i++) begin : g_route
    logic to_a;
    assign to_a     = (init_adr[i][AW-1 -: RGN_W] == T0_RGN);
    assign req_a[i] = init_cyc[i] && to_a;
    assign req_b[i] = init_cyc[i] && !to_a;
  end

  dci_chan_merge #(.N(NI), .AW(AW), .DW(DW), .SW(SW)) u_chan_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_a),
    .stb      (init_stb),
    .we       (init_we),
    .sel      (init_sel),
    .adr      (init_adr),
    .wdat     (init_wdat),
    .ch_cyc   (tgt_cyc[0]),
    .ch_stb   (tgt_stb[0]),
    .ch_we    (tgt_we[0]),
    .ch_sel   (tgt_sel[0]),
    .ch_adr   (tgt_adr[0]),
    .ch_wdat  (tgt_wdat[0]),
    .ch_ack   (tgt_ack[0]),
    .ch_err   (tgt_err[0]),
    .ch_rdat  (tgt_rdat[0]),
    .rsp_ack  (a_ack),
    .rsp_err  (a_err),
    .rsp_rdat (a_rdat)
  );

  dci_chan_merge #(.N(NI), .AW(AW), .DW(DW), .SW(SW)) u_chan_b (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_b),
    .stb      (init_stb),
    .we       (init_we),
    .sel      (init_sel),
    .adr      (init_adr),
    .wdat     (init_wdat),
    .ch_cyc   (z_cyc),
    .ch_stb   (z_stb),
    .ch_we    (z_we),
    .ch_sel   (z_sel),
    .ch_adr   (z_adr),
    .ch_wdat  (z_wdat),
    .ch_ack   (z_ack),
    .ch_err   (z_err),
    .ch_rdat  (z_rdat),
    .rsp_ack  (b_ack),
    .rsp_err  (b_err),
    .rsp_rdat (b_rdat)
  );

  dci_chan_split #(.NB(NB), .AW(AW), .DW(DW), .SW(SW), .B_BASE(B_BASE)) u_split_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .ch_cyc  (z_cyc),
    .ch_stb  (z_stb),
    .ch_we   (z_we),
    .ch_sel  (z_sel),
    .ch_adr  (z_adr),
    .ch_wdat (z_wdat),
    .ch_ack  (z_ack),
    .ch_err  (z_err),
    .ch_rdat (z_rdat),
    .t_cyc   (tgt_cyc[NB:1]),
    .t_stb   (tgt_stb[NB:1]),
    .t_we    (tgt_we[NB:1]),
    .t_sel   (tgt_sel[NB:1]),
    .t_adr   (tgt_adr[NB:1]),
    .t_wdat  (tgt_wdat[NB:1]),
    .t_rdat  (tgt_rdat[NB:1]),
    .t_ack   (tgt_ack[NB:1]),
    .t_err   (tgt_err[NB:1])
  );

  // response merge: each channel zeroes ungranted initiators, so OR is exact
  assign init_ack = a_ack | b_ack;
  assign init_err = a_err | b_err;
  for (genvar i = 0; i < NI; i++) begin : g_merge
    assign init_rdat[i] = a_rdat[i] | b_rdat[i];

    assert_rsp_needs_cyc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (init_ack[i] || init_err[i]) |-> init_cyc[i]);
  end

  assert_no_ack_and_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_ack & init_err) == '0 || (tgt_err != '0));
endmodule

// File: tb/dual_chan_xbar_bench.sv
module dual_chan_xbar_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 8;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [NI-1:0]         i_cyc = '0, i_stb = '0, i_we = '0;
  logic [NI-1:0][3:0]    i_sel = '0;
  logic [NI-1:0][31:0]   i_adr = '0, i_wdat = '0;
  logic [NI-1:0][31:0]   o_rdat;
  logic [NI-1:0]         o_ack, o_err;
  logic [NB:0]           t_cyc, t_stb, t_we;
  logic [NB:0][3:0]      t_sel;
  logic [NB:0][31:0]     t_adr, t_wdat, t_rdat;
  logic [NB:0]           t_ack, t_err;
  logic [NB:0]           stall = '0;

  dual_chan_xbar u_dual_chan_xbar (
    .clk(clk), .rst_n(rst_n),
    .init_cyc(i_cyc), .init_stb(i_stb), .init_we(i_we), .init_sel(i_sel),
    .init_adr(i_adr), .init_wdat(i_wdat), .init_rdat(o_rdat),
    .init_ack(o_ack), .init_err(o_err),
    .tgt_cyc(t_cyc), .tgt_stb(t_stb), .tgt_we(t_we), .tgt_sel(t_sel),
    .tgt_adr(t_adr), .tgt_wdat(t_wdat), .tgt_rdat(t_rdat),
    .tgt_ack(t_ack), .tgt_err(t_err)
  );

  // target models: zero-wait acknowledge unless stalled; data tags the target
  for (genvar t = 0; t <= NB; t++) begin : g_tm
    assign t_ack[t]  = t_cyc[t] && t_stb[t] && !stall[t];
    assign t_err[t]  = 1'b0;
    assign t_rdat[t] = t_ack[t] ? {8'(t), t_adr[t][23:0]} : 32'h0;
  end

  int n_chk = 0, n_fail = 0;

  typedef struct { int ini; logic err; logic [31:0] rdat; string tag; } exp_t;
  exp_t sbq[$];

  function automatic logic [31:0] model_rdat(input logic [31:0] a);
    int r;
    r = int'(a[31:28]);
    if (r <= 8) return {8'(r), a[23:0]};
    return 32'h0;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_rsp(input int ini, input logic [31:0] a, input string tag);
    exp_t e;
    e.ini  = ini;
    e.err  = (a[31:28] > 4'd8);
    e.rdat = model_rdat(a);
    e.tag  = tag;
    sbq.push_back(e);
  endtask

  // monitor: pop one expected item per acknowledge or error seen
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NI; i++) begin
        if (o_ack[i] || o_err[i]) begin
          if (sbq.size() == 0) begin
            chk(1'b0, "R10 unexpected response", 32'(i), 32'hFFFF_FFFF);
          end else begin
            exp_t e;
            e = sbq.pop_front();
            chk(e.ini == i, {e.tag, " initiator order"}, 32'(i), 32'(e.ini));
            chk(o_err[i] == e.err && o_ack[i] == !e.err, {e.tag, " err/ack"},
                32'({o_ack[i], o_err[i]}), 32'({!e.err, e.err}));
            chk(o_rdat[i] == e.rdat, {e.tag, " rdat"}, o_rdat[i], e.rdat);
          end
        end
      end
    end
  end

  task automatic xfer(input int ini, input logic [31:0] a, input logic w, input logic [31:0] wd);
    @(posedge clk); #1;
    i_cyc[ini] = 1'b1; i_stb[ini] = 1'b1; i_we[ini] = w;
    i_adr[ini] = a; i_wdat[ini] = wd; i_sel[ini] = 4'hF;
    do @(negedge clk); while (!(o_ack[ini] || o_err[ini]));
    @(posedge clk); #1;
    i_cyc[ini] = 1'b0; i_stb[ini] = 1'b0; i_we[ini] = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    chk(t_cyc == '0, "R9 tgt_cyc in reset", 32'(t_cyc), 32'h0);
    chk(o_ack == '0 && o_err == '0, "R9 ack/err in reset", 32'({o_ack, o_err}), 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1: write to target 0 passes through in the same cycle
    expect_rsp(3, 32'h0000_1234, "R1");
    fork
      xfer(3, 32'h0000_1234, 1'b1, 32'hCAFE_0001);
      begin
        @(posedge clk); @(negedge clk);
        chk(t_cyc[0] && t_stb[0] && t_we[0], "R1 target0 strobe", 32'({t_cyc[0], t_stb[0], t_we[0]}), 32'h7);
        chk(t_adr[0] == 32'h0000_1234, "R1 target0 adr", t_adr[0], 32'h0000_1234);
        chk(t_wdat[0] == 32'hCAFE_0001, "R1 target0 wdat", t_wdat[0], 32'hCAFE_0001);
        chk(t_sel[0] == 4'hF, "R1 target0 sel", 32'(t_sel[0]), 32'hF);
      end
    join

    // R2: each target 1..8 reached by its region nibble
    for (int k = 1; k <= 8; k++) begin
      logic [31:0] a;
      a = {4'(k), 4'h0, 24'h00_0100 + 24'(k)};
      expect_rsp(k - 1, a, "R2");
      xfer(k - 1, a, 1'b0, 32'h0);
    end

    // R3: target 0 and target 6 used concurrently
    expect_rsp(0, 32'h0000_0040, "R3");
    expect_rsp(4, 32'h6000_0044, "R3");
    fork
      xfer(0, 32'h0000_0040, 1'b0, 32'h0);
      xfer(4, 32'h6000_0044, 1'b0, 32'h0);
      begin
        @(posedge clk); @(negedge clk);
        chk(t_cyc[0] && t_cyc[6], "R3 both channels active", 32'(t_cyc), 32'h41);
      end
    join

    // R4, R8, R10: channel B busy, second initiator waits
    stall[3] = 1'b1;
    expect_rsp(1, 32'h3000_0010, "R10");
    expect_rsp(2, 32'h5000_0020, "R10");
    fork
      xfer(1, 32'h3000_0010, 1'b0, 32'h0);
      xfer(2, 32'h5000_0020, 1'b0, 32'h0);
      begin
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(t_cyc[3] && !t_cyc[5], "R4 only one B target", 32'(t_cyc), 32'h8);
        chk(!o_ack[2] && !o_err[2], "R8 waiting ack/err zero", 32'({o_ack[2], o_err[2]}), 32'h0);
        chk(o_rdat[2] == 32'h0, "R8 waiting rdat zero", o_rdat[2], 32'h0);
        @(posedge clk); #2 stall[3] = 1'b0;
      end
    join

    // R5: owner 3 releases; requesters 1 and 5 -> 5 wins by round robin
    stall[2] = 1'b1;
    expect_rsp(3, 32'h2000_0030, "R5");
    expect_rsp(5, 32'h7000_0050, "R5");
    expect_rsp(1, 32'h4000_0060, "R5");
    fork
      xfer(3, 32'h2000_0030, 1'b0, 32'h0);
      begin repeat (2) @(posedge clk); xfer(1, 32'h4000_0060, 1'b0, 32'h0); end
      begin repeat (2) @(posedge clk); xfer(5, 32'h7000_0050, 1'b0, 32'h0); end
      begin repeat (3) @(posedge clk); #2 stall[2] = 1'b0; end
    join

    // R6: init 2 holds target 0 although init 0 is ahead in round robin
    stall[0] = 1'b1;
    expect_rsp(2, 32'h0000_0222, "R6");
    expect_rsp(0, 32'h0000_0111, "R6");
    fork
      xfer(2, 32'h0000_0222, 1'b0, 32'h0);
      begin @(posedge clk); xfer(0, 32'h0000_0111, 1'b0, 32'h0); end
      begin
        repeat (3) @(posedge clk); @(negedge clk);
        chk(t_adr[0] == 32'h0000_0222, "R6 grant held", t_adr[0], 32'h0000_0222);
        chk(!o_ack[0], "R6 challenger waits", 32'(o_ack[0]), 32'h0);
        @(posedge clk); #2 stall[0] = 1'b0;
      end
    join

    // R7: unmapped region gives a one-cycle error, one cycle late
    expect_rsp(6, 32'hA000_0000, "R7");
    fork
      xfer(6, 32'hA000_0000, 1'b0, 32'h0);
      begin
        @(posedge clk); @(negedge clk);
        chk(t_cyc == '0, "R7 no target cycle", 32'(t_cyc), 32'h0);
        chk(!o_err[6] && !o_ack[6], "R7 error not yet", 32'({o_ack[6], o_err[6]}), 32'h0);
        @(negedge clk);
        chk(o_err[6], "R7 error due", 32'(o_err[6]), 32'h1);
        @(negedge clk);
        chk(!o_err[6], "R7 error one cycle", 32'(o_err[6]), 32'h0);
      end
    join
    expect_rsp(7, 32'hF000_0004, "R7");
    xfer(7, 32'hF000_0004, 1'b1, 32'h5);

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R10 all responses seen", 32'(sbq.size()), 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule